// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a small bank of control registers for a workstation I/O controller. Software reaches it over a simple synchronous register bus that has an address, separate write and read strobes, four byte enables and 32-bit data. It holds byte-wide configuration, diagnostic, modem-control and two auxiliary registers, a 16-bit indicator-light register and a 32-bit system-control register.

Several of these registers have side effects, so they do not act as plain storage. One auxiliary bit fires a single-cycle terminal-count pulse toward a floppy controller and is never stored. A sticky power-fail status bit can be set only while power interrupts are enabled, and a separate write bit clears it. A power-off request and a system-reset request are raised by writes and held until an acknowledge arrives. A warm reset leaves the diagnostic, indicator-light and system-control contents in place.

The power-failing input is asynchronous. The block passes it through a synchroniser before it affects any state.

Top module: `auxctl_bank`

## Requirements
- R1: `pwr_irq` is high exactly when auxiliary-2 bit 5 (power-fail status) and configuration bit 3 (power-interrupt enable) are both set. It follows writes to either register in the cycle after the write.
- R2: `pwr_fail_async` passes through a two-flop synchroniser. At each change of the synchronised level, auxiliary-2 bit 5 takes the value (level AND configuration bit 3), with the result stored on the third clock edge after the input changes. A configuration write alone never changes bit 5.
- R3: A write to auxiliary-2 takes only data bits 0 (power off) and 1 (clear power-fail) and carries the current bit 5 over. All other bits read as zero, and bit 1 is never stored.
- R4: An auxiliary-2 write with data bit 1 set clears bit 5 and keeps only bit 0 from the data.
- R5: An auxiliary-2 write whose result has bit 0 set raises `pwroff_req`. The request stays high until a cycle with `req_ack` high drops it.
- R6: A write to auxiliary-1 with data bit 1 set produces a one-cycle high pulse on `fdc_tc`. The other seven bits are stored, and bit 1 always reads back as zero.
- R7: A system-control write with data bit 0 set loads the register with 0x02 and raises `sysrst_req`, which is held until `req_ack`. A write with bit 0 clear changes nothing.
- R8: The register window is selected by address bits [5:3] (0 configuration, 1 diagnostic, 2 modem, 3 auxiliary-1, 4 auxiliary-2, 5 indicator lights, 6 system control). Address bits [2:0] give the offset. An access of the right size at a nonzero offset reads zero, ignores the write and raises no error.
- R9: The access size is the number of set byte enables. Windows 0 to 4 need size 1, window 5 needs size 2 and window 6 needs size 4. A mismatched access leaves all registers unchanged and reads zero, and `bus_err` pulses high for one cycle after it.
- R10: Reset (`rst_n` low at a clock edge) clears configuration, modem, auxiliary-1, auxiliary-2 and both requests. The diagnostic, indicator-light and system-control registers keep their contents.
- R11: Data is right-justified in `bus_wdata` and `bus_rdata`. Configuration, diagnostic and modem store all eight bits, and the indicator-light register stores all 16 bits. Read data appears in the cycle after `bus_rd` and holds until the next read.
- R12: When an auxiliary-2 write and a synchronised input change land on the same edge, the input evaluation is applied after the write, so the input decides bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address: window in [5:3], offset in [2:0] |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte enables; the count of set bits gives the access size |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an access of the wrong size |
| pwr_fail_async | input | 1 | Asynchronous power-failing level |
| req_ack | input | 1 | Acknowledge that drops held requests |
| pwr_irq | output | 1 | Level power-fail interrupt |
| fdc_tc | output | 1 | One-cycle terminal-count pulse |
| pwroff_req | output | 1 | Held power-off request |
| sysrst_req | output | 1 | Held system-reset request |

## Verification
The clear-interrupt write to auxiliary-2 and a change of the synchronised power-failing level can both update the status bit on the same edge. The bench provokes this by raising the input and then issuing the clearing write exactly two cycles later, so the write is captured on the edge where the synchronised change is evaluated. The expected result is that the input wins: the status bit reads back set and the interrupt stays high. An assertion separately covers the case where a clearing write arrives with no input change, which must leave the bit cleared.

// File: rtl/auxctl_pkg.sv
// Package: shared window codes, field positions and size lookup for the
// auxiliary control bank. Assumes the window is decoded from three address bits.
package auxctl_pkg;

    typedef enum logic [2:0] {
        WIN_CFG    = 3'd0,
        WIN_DIAG   = 3'd1,
        WIN_MODEM  = 3'd2,
        WIN_AUX1   = 3'd3,
        WIN_AUX2   = 3'd4,
        WIN_LED    = 3'd5,
        WIN_SYSCTL = 3'd6,
        WIN_NONE   = 3'd7
    } win_e;

    localparam int CFG_PFEN_BIT = 3;
    localparam int AUX1_TC_BIT  = 1;
    localparam int AUX2_OFF_BIT = 0;
    localparam int AUX2_CLR_BIT = 1;
    localparam int AUX2_PF_BIT  = 5;
    localparam int SYS_RST_BIT  = 0;
    localparam logic [31:0] SYS_STATUS_VAL = 32'h0000_0002;

    // Number of bytes a window accepts; zero means no register there.
    function automatic logic [2:0] win_bytes(input win_e w);
        case (w)
            WIN_LED:    win_bytes = 3'd2;
            WIN_SYSCTL: win_bytes = 3'd4;
            WIN_NONE:   win_bytes = 3'd0;
            default:    win_bytes = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/auxctl_sync.sv
// Multi-stage level synchroniser. Assumes the input is a slow level and that
// reset drives every stage to zero.
module auxctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/auxctl_decode.sv
// Access decoder: splits the address into window and offset, counts byte
// enables and judges whether the access size fits the window. Purely
// combinational; assumes the window is held in the top three address bits.
module auxctl_decode
    import auxctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BE_W   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    output win_e              win,
    output logic              size_ok,
    output logic              size_bad,
    output logic              at_base
);
    localparam int OFF_W = ADDR_W - 3;
    localparam int CNT_W = $clog2(BE_W + 1);

    logic [CNT_W-1:0] be_cnt;

    // Count the asserted byte enables to get the access size.
    always_comb begin
        be_cnt = '0;
        for (int i = 0; i < BE_W; i++) be_cnt = be_cnt + CNT_W'(be[i]);
    end

    // Classify the access against the window's allowed width.
    always_comb begin
        win      = win_e'(addr[ADDR_W-1:OFF_W]);
        at_base  = (addr[OFF_W-1:0] == '0);
        size_ok  = (win != WIN_NONE) && (3'(be_cnt) == win_bytes(win));
        size_bad = (win != WIN_NONE) && !size_ok;
    end
endmodule

// File: rtl/auxctl_power.sv
// Auxiliary-2 power register: sticky power-fail status, clear bit, power-off
// bit and the power-off request trigger. Assumes pf_sync is already
// synchronised; an input change is applied after a same-cycle write.
module auxctl_power
    import auxctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pf_sync,
    input  logic       pf_enable,
    input  logic       wr_stb,
    input  logic [1:0] wr_bits,
    output logic [7:0] aux2,
    output logic       pwroff_set
);
    logic [7:0] aux2_q;
    logic [7:0] aux2_d;
    logic       pf_prev_q;
    logic       pf_change;

    assign pf_change = (pf_sync != pf_prev_q);

    // Build the next register value: write first, then input evaluation.
    always_comb begin
        aux2_d = aux2_q;
        if (wr_stb) begin
            aux2_d               = 8'h00;
            aux2_d[AUX2_OFF_BIT] = wr_bits[AUX2_OFF_BIT];
            aux2_d[AUX2_PF_BIT]  = wr_bits[AUX2_CLR_BIT] ? 1'b0 : aux2_q[AUX2_PF_BIT];
        end
        if (pf_change) aux2_d[AUX2_PF_BIT] = pf_sync & pf_enable;
    end

    // Hold the register and the last seen synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux2_q    <= 8'h00;
            pf_prev_q <= 1'b0;
        end else begin
            aux2_q    <= aux2_d;
            pf_prev_q <= pf_sync;
        end
    end

    assign aux2       = aux2_q;
    assign pwroff_set = wr_stb & wr_bits[AUX2_OFF_BIT];

    // R3: only the power-off and power-fail bits can ever be stored.
    p_aux2_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (aux2_q & 8'hDE) == 8'h00);

    // R4: a clearing write with no input change leaves the status clear.
    p_pf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_bits[AUX2_CLR_BIT] && !pf_change) |=> !aux2_q[AUX2_PF_BIT]);

    // R2: the status can only rise while the enable was set.
    p_pf_rise_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux2_q[AUX2_PF_BIT]) |-> $past(pf_enable));
endmodule

// File: rtl/auxctl_reqhold.sv
// Held request: set by a one-cycle trigger, dropped by an acknowledge.
// Assumes set has priority over a same-cycle acknowledge.
module auxctl_reqhold (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic req
);
    logic req_q;

    // Set on trigger, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   req_q <= 1'b0;
        else if (set) req_q <= 1'b1;
        else if (ack) req_q <= 1'b0;
    end

    assign req = req_q;

    // R5: a raised request stays up until acknowledged.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !ack) |=> req_q);
endmodule

// File: rtl/auxctl_bank.sv
// Top of the auxiliary control bank: bus decode, byte/halfword/word
// registers, side-effect pulses and held requests. Assumes right-justified
// data, one access per cycle and a synchronous active-low reset that spares
// the diagnostic, indicator-light and system-control registers.
module auxctl_bank
    import auxctl_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 32,
    parameter int BE_W        = DATA_W / 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              pwr_fail_async,
    input  logic              req_ack,
    output logic              pwr_irq,
    output logic              fdc_tc,
    output logic              pwroff_req,
    output logic              sysrst_req
);
    localparam int NUM_REQ = 2;
    localparam int REQ_OFF = 0;
    localparam int REQ_RST = 1;

    win_e        win;
    logic        size_ok, size_bad, at_base;
    logic        acc_ok;
    logic [7:0]  cfg_q, modem_q, aux1_q, diag_q;
    logic [15:0] led_q;
    logic [DATA_W-1:0] sys_q;
    logic [7:0]  aux2;
    logic        pf_sync;
    logic        tc_q, err_q;
    logic [DATA_W-1:0] rdata_q, rd_val;
    logic        wr_cfg, wr_diag, wr_modem, wr_aux1, wr_aux2, wr_led, wr_sys;
    logic        pwroff_set, sys_fire;
    logic [NUM_REQ-1:0] req_set, req_out;
    logic        unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:16];

    auxctl_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_decode (
        .addr     (bus_addr),
        .be       (bus_be),
        .win      (win),
        .size_ok  (size_ok),
        .size_bad (size_bad),
        .at_base  (at_base)
    );

    auxctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pwr_fail_async),
        .q_sync  (pf_sync)
    );

    assign acc_ok = size_ok & at_base;

    // Per-register write strobes for accepted accesses.
    always_comb begin
        wr_cfg   = bus_wr && acc_ok && (win == WIN_CFG);
        wr_diag  = bus_wr && acc_ok && (win == WIN_DIAG);
        wr_modem = bus_wr && acc_ok && (win == WIN_MODEM);
        wr_aux1  = bus_wr && acc_ok && (win == WIN_AUX1);
        wr_aux2  = bus_wr && acc_ok && (win == WIN_AUX2);
        wr_led   = bus_wr && acc_ok && (win == WIN_LED);
        wr_sys   = bus_wr && acc_ok && (win == WIN_SYSCTL);
        sys_fire = wr_sys && bus_wdata[SYS_RST_BIT];
    end

    auxctl_power u_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .pf_sync    (pf_sync),
        .pf_enable  (cfg_q[CFG_PFEN_BIT]),
        .wr_stb     (wr_aux2),
        .wr_bits    (bus_wdata[1:0]),
        .aux2       (aux2),
        .pwroff_set (pwroff_set)
    );

    assign req_set[REQ_OFF] = pwroff_set;
    assign req_set[REQ_RST] = sys_fire;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        auxctl_reqhold u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (req_set[g]),
            .ack   (req_ack),
            .req   (req_out[g])
        );
    end

    // Registers cleared by reset, plus the pulse and error flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= 8'h00;
            modem_q <= 8'h00;
            aux1_q  <= 8'h00;
            tc_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (wr_cfg)   cfg_q   <= bus_wdata[7:0];
            if (wr_modem) modem_q <= bus_wdata[7:0];
            if (wr_aux1)  aux1_q  <= bus_wdata[7:0] & ~(8'h01 << AUX1_TC_BIT);
            tc_q  <= wr_aux1 && bus_wdata[AUX1_TC_BIT];
            err_q <= (bus_wr || bus_rd) && size_bad;
        end
    end

    // Registers that survive reset.
    always_ff @(posedge clk) begin
        if (wr_diag)  diag_q <= bus_wdata[7:0];
        if (wr_led)   led_q  <= bus_wdata[15:0];
        if (sys_fire) sys_q  <= SYS_STATUS_VAL;
    end

    // Select read data for an accepted access; all else reads zero.
    always_comb begin
        rd_val = '0;
        if (acc_ok) begin
            case (win)
                WIN_CFG:    rd_val = DATA_W'(cfg_q);
                WIN_DIAG:   rd_val = DATA_W'(diag_q);
                WIN_MODEM:  rd_val = DATA_W'(modem_q);
                WIN_AUX1:   rd_val = DATA_W'(aux1_q);
                WIN_AUX2:   rd_val = DATA_W'(aux2);
                WIN_LED:    rd_val = DATA_W'(led_q);
                WIN_SYSCTL: rd_val = sys_q;
                default:    rd_val = '0;
            endcase
        end
    end

    // Capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_val;
    end

    assign bus_rdata  = rdata_q;
    assign bus_err    = err_q;
    assign fdc_tc     = tc_q;
    assign pwroff_req = req_out[REQ_OFF];
    assign sysrst_req = req_out[REQ_RST];
    assign pwr_irq    = aux2[AUX2_PF_BIT] & cfg_q[CFG_PFEN_BIT];

    // R6: the terminal-count bit is never held in auxiliary-1.
    p_aux1_tc_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !aux1_q[AUX1_TC_BIT]);

    // R7: the reset request only rises with the status value loaded.
    p_sysrst_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysrst_req) |-> (sys_q == SYS_STATUS_VAL));

    // R9: an error pulse always follows a bus access.
    p_err_after_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_wr || bus_rd));

    // R1: the interrupt never shows without the enable bit.
    p_irq_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_irq |-> cfg_q[CFG_PFEN_BIT]);
endmodule

// File: tb/auxctl_bank_tb.sv
module auxctl_bank_tb;
    localparam int W_CFG = 0, W_DIAG = 1, W_MODEM = 2, W_AUX1 = 3,
                   W_AUX2 = 4, W_LED = 5, W_SYS = 6;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        pwr_fail_async = 1'b0, req_ack = 1'b0;
    logic        pwr_irq, fdc_tc, pwroff_req, sysrst_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit rd_seen = 1'b0;
    rd_item_t rd_q[$];

    always #5 clk = ~clk;

    auxctl_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err),
        .pwr_fail_async(pwr_fail_async), .req_ack(req_ack),
        .pwr_irq(pwr_irq), .fdc_tc(fdc_tc), .pwroff_req(pwroff_req),
        .sysrst_req(sysrst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int w, input int off, input logic [3:0] be, input logic [31:0] d);
        bus_addr  = 6'((w << 3) | off);
        bus_be    = be;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // Driver: pushes the expected value, then issues the read.
    task automatic bus_read(input int w, input int off, input logic [3:0] be,
                            input logic [31:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp;
        it.tag = tag;
        rd_q.push_back(it);
        bus_addr = 6'((w << 3) | off);
        bus_be   = be;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: note reads captured at each edge.
    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: compare captured read data against the scoreboard.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (rd_q.size() == 0) begin
                check("R11 unexpected read", 32'h1, 32'h0);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R10 reset state
        check("R10 irq after reset", 32'(pwr_irq), 0);
        check("R10 tc after reset", 32'(fdc_tc), 0);
        check("R10 pwroff after reset", 32'(pwroff_req), 0);
        check("R10 sysrst after reset", 32'(sysrst_req), 0);
        check("R10 err after reset", 32'(bus_err), 0);
        bus_read(W_CFG, 0, 4'b0001, 32'h0, "R10 cfg reset");
        bus_read(W_AUX1, 0, 4'b0001, 32'h0, "R10 aux1 reset");
        bus_read(W_AUX2, 0, 4'b0001, 32'h0, "R10 aux2 reset");
        bus_read(W_MODEM, 0, 4'b0001, 32'h0, "R10 modem reset");

        // R11 plain storage
        bus_write(W_CFG, 0, 4'b0001, 32'hFFFF_FF08);
        bus_write(W_DIAG, 0, 4'b0001, 32'h0000_00A5);
        bus_write(W_MODEM, 0, 4'b0001, 32'h0000_003C);
        bus_write(W_LED, 0, 4'b0011, 32'h0000_BEEF);
        bus_read(W_CFG, 0, 4'b0001, 32'h08, "R11 cfg readback");
        bus_read(W_DIAG, 0, 4'b0001, 32'hA5, "R11 diag readback");
        bus_read(W_MODEM, 0, 4'b0001, 32'h3C, "R11 modem readback");
        bus_read(W_LED, 0, 4'b0011, 32'hBEEF, "R11 led readback");
        check("R1 irq idle", 32'(pwr_irq), 0);

        // R6 terminal-count pulse
        bus_write(W_AUX1, 0, 4'b0001, 32'hFF);
        check("R6 tc pulse high", 32'(fdc_tc), 1);
        idle(1);
        check("R6 tc pulse one cycle", 32'(fdc_tc), 0);
        bus_read(W_AUX1, 0, 4'b0001, 32'hFD, "R6 aux1 bit1 zero");
        bus_write(W_AUX1, 0, 4'b0001, 32'h01);
        check("R6 no pulse without bit1", 32'(fdc_tc), 0);

        // R2 power-fail set through the synchroniser
        pwr_fail_async = 1'b1;
        idle(4);
        bus_read(W_AUX2, 0, 4'b0001, 32'h20, "R2 status set");
        check("R1 irq raised", 32'(pwr_irq), 1);
        bus_write(W_CFG, 0, 4'b0001, 32'h00);
        check("R1 irq follows cfg clear", 32'(pwr_irq), 0);
        bus_read(W_AUX2, 0, 4'b0001, 32'h20, "R2 status kept on cfg write");
        bus_write(W_CFG, 0, 4'b0001, 32'h08);
        check("R1 irq follows cfg set", 32'(pwr_irq), 1);

        // R3 write keeps status, masks bits
        bus_write(W_AUX2, 0, 4'b0001, 32'hFC);
        bus_read(W_AUX2, 0, 4'b0001, 32'h20, "R3 carry status mask others");
        check("R5 no pwroff without bit0", 32'(pwroff_req), 0);
        // R4 clear
        bus_write(W_AUX2, 0, 4'b0001, 32'h02);
        bus_read(W_AUX2, 0, 4'b0001, 32'h00, "R4 clear status");
        check("R4 irq dropped", 32'(pwr_irq), 0);

        // R2 enable gating
        pwr_fail_async = 1'b0;
        idle(4);
        bus_write(W_CFG, 0, 4'b0001, 32'h00);
        pwr_fail_async = 1'b1;
        idle(4);
        bus_read(W_AUX2, 0, 4'b0001, 32'h00, "R2 no set while disabled");
        bus_write(W_CFG, 0, 4'b0001, 32'h08);
        bus_read(W_AUX2, 0, 4'b0001, 32'h00, "R2 cfg write does not set");
        check("R2 irq stays low", 32'(pwr_irq), 0);
        pwr_fail_async = 1'b0;
        idle(4);

        // R5 power-off request
        bus_write(W_AUX2, 0, 4'b0001, 32'h01);
        check("R5 pwroff raised", 32'(pwroff_req), 1);
        bus_read(W_AUX2, 0, 4'b0001, 32'h01, "R3 power-off bit stored");
        idle(3);
        check("R5 pwroff held", 32'(pwroff_req), 1);
        req_ack = 1'b1;
        idle(1);
        req_ack = 1'b0;
        check("R5 pwroff dropped by ack", 32'(pwroff_req), 0);

        // R7 system control
        bus_write(W_SYS, 0, 4'b1111, 32'h0);
        check("R7 no reset on bit0 clear", 32'(sysrst_req), 0);
        bus_write(W_SYS, 0, 4'b1111, 32'h1);
        check("R7 reset raised", 32'(sysrst_req), 1);
        bus_read(W_SYS, 0, 4'b1111, 32'h2, "R7 status value");
        idle(2);
        check("R7 reset held", 32'(sysrst_req), 1);
        req_ack = 1'b1;
        idle(1);
        req_ack = 1'b0;
        check("R7 reset dropped by ack", 32'(sysrst_req), 0);

        // R8 nonzero offsets
        bus_write(W_LED, 2, 4'b0011, 32'h1234);
        check("R8 no error at offset", 32'(bus_err), 0);
        bus_read(W_LED, 0, 4'b0011, 32'hBEEF, "R8 led unchanged");
        bus_read(W_LED, 2, 4'b0011, 32'h0, "R8 led offset reads zero");
        bus_read(W_SYS, 4, 4'b1111, 32'h0, "R8 sys offset reads zero");
        bus_write(W_SYS, 4, 4'b1111, 32'h1);
        check("R8 sys offset write ignored", 32'(sysrst_req), 0);

        // R9 size mismatches
        bus_write(W_CFG, 0, 4'b1111, 32'h0);
        check("R9 err on cfg word write", 32'(bus_err), 1);
        idle(1);
        check("R9 err one cycle", 32'(bus_err), 0);
        bus_read(W_CFG, 0, 4'b0001, 32'h08, "R9 cfg unchanged");
        bus_read(W_LED, 0, 4'b0001, 32'h0, "R9 led byte read zero");
        check("R9 err on led byte read", 32'(bus_err), 1);
        bus_write(W_SYS, 0, 4'b0011, 32'h1);
        check("R9 sys half write no reset", 32'(sysrst_req), 0);
        check("R9 err on sys half write", 32'(bus_err), 1);

        // R10 warm reset keeps some registers
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        bus_read(W_DIAG, 0, 4'b0001, 32'hA5, "R10 diag kept");
        bus_read(W_LED, 0, 4'b0011, 32'hBEEF, "R10 led kept");
        bus_read(W_SYS, 0, 4'b1111, 32'h2, "R10 sys kept");
        bus_read(W_CFG, 0, 4'b0001, 32'h0, "R10 cfg cleared");
        bus_read(W_MODEM, 0, 4'b0001, 32'h0, "R10 modem cleared");

        // R12 clearing write on the edge the input change is evaluated
        bus_write(W_CFG, 0, 4'b0001, 32'h08);
        pwr_fail_async = 1'b1;
        idle(2);
        bus_write(W_AUX2, 0, 4'b0001, 32'h02);
        check("R12 irq kept by input", 32'(pwr_irq), 1);
        bus_read(W_AUX2, 0, 4'b0001, 32'h20, "R12 input wins over clear");

        idle(3);
        check("R11 scoreboard drained", 32'(rd_q.size()), 0);
        finish_run();
    end
endmodule